// File: doc/BRIEF.md
# Top-Priority Interrupt Request Controller

This block raises one interrupt request that outranks every other request in the system. The trigger comes from one of two places, chosen by a configuration bit: an external pin, brought into the clock domain and watched for a programmable edge, or a one-cycle end-of-count pulse from a watchdog counter. When the chosen trigger fires, a pending flag is latched. The pending flag reaches the request output through either of two enable paths. One is a maskable enable that also needs the core's global interrupt enable. The other is a set-only override that ignores the global enable and that only reset can clear.

When the core acknowledges the request, the block clears the pending flag and enters an in-service state. It holds a block-others output high until the core signals the matching return. While that output is high, the block issues no new request of its own, even when a fresh trigger is pending. The global interrupt enable is an input only. The block never drives it and keeps no priority level, so taking the interrupt and returning from it leave both unchanged.

Top module: `toplvl_irq_ctrl`

## Requirements
- R1: After reset the request, pending and block-others outputs are 0. The source select is set to the pin, the edge polarity is falling, and both enables are clear.
- R2: With the pin source and rising polarity (`ctl_rise_i`=1), a 0-to-1 change on the pin sets the pending flag on the third rising clock edge after the change. A 1-to-0 change does not set it.
- R3: With the pin source and falling polarity (`ctl_rise_i`=0), a 1-to-0 pin change sets the pending flag with the same latency. A 0-to-1 change does not set it.
- R4: With the watchdog source (`ctl_src_pin_i`=0), a one-cycle watchdog pulse sets the pending flag at the next clock edge, and pin edges are ignored.
- R5: With the pin source (`ctl_src_pin_i`=1), watchdog pulses are ignored.
- R6: When the set-only enable is clear, the request is high exactly when the flag is pending, the maskable enable is 1, the global enable is 1, and no service is active.
- R7: Writing 1 to `ctl_nm_i` sets the set-only enable, and writing 0 to it has no effect. While it is set, a pending flag produces a request whatever the global enable and maskable enable are.
- R8: An acknowledge clears the pending flag and sets block-others at the next edge. While block-others is high, the request stays low, even when a new trigger is pending.
- R9: A return strobe clears block-others at the next edge. A trigger left pending then raises the request. If acknowledge and return arrive in the same cycle, acknowledge wins.
- R10: A pending write loads `pend_wdata_i` into the flag and overrides an acknowledge in the same cycle. A trigger in the same cycle sets the flag whatever the write or acknowledge does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | 1 | External asynchronous trigger pin |
| wdog_eoc_i | input | 1 | Watchdog end-of-count, one-cycle pulse |
| gie_i | input | 1 | Global interrupt enable from the core |
| ctl_wr_i | input | 1 | Write strobe for the control fields |
| ctl_src_pin_i | input | 1 | Source select: 1 pin, 0 watchdog |
| ctl_rise_i | input | 1 | Edge polarity: 1 rising, 0 falling |
| ctl_mask_i | input | 1 | Maskable enable |
| ctl_nm_i | input | 1 | Set-only enable (1 sets, 0 ignored) |
| pend_wr_i | input | 1 | Write strobe for the pending flag |
| pend_wdata_i | input | 1 | Value written to the pending flag |
| ack_i | input | 1 | Interrupt acknowledge from the core |
| ret_i | input | 1 | Return-from-service strobe |
| irq_o | output | 1 | Top-priority interrupt request |
| pend_o | output | 1 | Pending flag |
| block_o | output | 1 | Block all other requests while in service |

## Verification
If the set-only enable clears by mistake, the request drops once the global enable goes low. That shows on the next pending write in the mask table. A stuck or missing in-service state shows up in one of two ways: a request during service, or a block-others output still high one edge after the return. A wrong synchronizer depth or a wrong edge sense moves the pending flag by a cycle, or sets it on the wrong transition. The bench samples the cycle before the expected edge and the cycle of it, so either fault shows at the port.

// File: rtl/toplvl_irq_pkg.sv
package toplvl_irq_pkg;

  typedef struct packed {
    logic src_pin;
    logic rise;
    logic mask_en;
    logic nm_en;
  } tirq_cfg_t;

  localparam tirq_cfg_t TIRQ_CFG_RST = '{src_pin: 1'b1, rise: 1'b0,
                                         mask_en: 1'b0, nm_en: 1'b0};

  function automatic logic tirq_edge(input logic cur, input logic prev,
                                     input logic rise);
    return rise ? (cur & ~prev) : (~cur & prev);
  endfunction

  function automatic logic tirq_pick(input logic src_pin, input logic pin_evt,
                                     input logic wdog_evt);
    return src_pin ? pin_evt : wdog_evt;
  endfunction

  function automatic logic tirq_pend_next(input logic cur, input logic wr,
                                          input logic wdata, input logic ack,
                                          input logic evt);
    logic base;
    if (wr)       base = wdata;
    else if (ack) base = 1'b0;
    else          base = cur;
    return base | evt;
  endfunction

  function automatic logic tirq_svc_next(input logic cur, input logic ack,
                                         input logic ret);
    if (ack)      return 1'b1;
    else if (ret) return 1'b0;
    else          return cur;
  endfunction

  function automatic logic tirq_request(input logic pend, input logic in_svc,
                                        input logic nm_en, input logic mask_en,
                                        input logic gie);
    return pend & ~in_svc & (nm_en | (mask_en & gie));
  endfunction

endpackage

// File: rtl/toplvl_irq_sync.sv
module toplvl_irq_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_LVL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic sync_o
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= RST_LVL;
          else        chain_q[g] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= RST_LVL;
          else        chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign sync_o = chain_q[LAST];
endmodule

// File: rtl/toplvl_irq_trigger.sv
module toplvl_irq_trigger
  import toplvl_irq_pkg::*;
#(
  parameter int   SYNC_STAGES = 2,
  parameter logic PIN_RST_LVL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  input  logic wdog_eoc_i,
  input  logic src_pin,
  input  logic rise,
  output logic pin_edge_o,
  output logic evt_o
);
  logic pin_sync;
  logic pin_prev_q;

  toplvl_irq_sync #(
    .STAGES (SYNC_STAGES),
    .RST_LVL(PIN_RST_LVL)
  ) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .async_i(pin_i),
    .sync_o (pin_sync)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_prev_q <= PIN_RST_LVL;
    else        pin_prev_q <= pin_sync;
  end

  assign pin_edge_o = tirq_edge(pin_sync, pin_prev_q, rise);
  assign evt_o      = tirq_pick(src_pin, pin_edge_o, wdog_eoc_i);
endmodule

// File: rtl/toplvl_irq_cfg.sv
module toplvl_irq_cfg
  import toplvl_irq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr_i,
  input  logic      src_pin_i,
  input  logic      rise_i,
  input  logic      mask_i,
  input  logic      nm_i,
  output tirq_cfg_t cfg_o
);
  tirq_cfg_t cfg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= TIRQ_CFG_RST;
    end else if (wr_i) begin
      cfg_q.src_pin <= src_pin_i;
      cfg_q.rise    <= rise_i;
      cfg_q.mask_en <= mask_i;
      cfg_q.nm_en   <= cfg_q.nm_en | nm_i;
    end
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/toplvl_irq_state.sv
module toplvl_irq_state
  import toplvl_irq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic evt_i,
  input  logic pend_wr_i,
  input  logic pend_wdata_i,
  input  logic ack_i,
  input  logic ret_i,
  output logic pend_o,
  output logic in_svc_o
);
  logic pend_q;
  logic svc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      svc_q  <= 1'b0;
    end else begin
      pend_q <= tirq_pend_next(pend_q, pend_wr_i, pend_wdata_i, ack_i, evt_i);
      svc_q  <= tirq_svc_next(svc_q, ack_i, ret_i);
    end
  end

  assign pend_o   = pend_q;
  assign in_svc_o = svc_q;
endmodule

// File: rtl/toplvl_irq_ctrl.sv
module toplvl_irq_ctrl
  import toplvl_irq_pkg::*;
#(
  parameter int   SYNC_STAGES = 2,
  parameter logic PIN_RST_LVL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  input  logic wdog_eoc_i,
  input  logic gie_i,
  input  logic ctl_wr_i,
  input  logic ctl_src_pin_i,
  input  logic ctl_rise_i,
  input  logic ctl_mask_i,
  input  logic ctl_nm_i,
  input  logic pend_wr_i,
  input  logic pend_wdata_i,
  input  logic ack_i,
  input  logic ret_i,
  output logic irq_o,
  output logic pend_o,
  output logic block_o
);
  tirq_cfg_t cfg;
  logic      trig_evt;
  logic      pin_edge;
  logic      pend;
  logic      in_svc;

  toplvl_irq_cfg u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_i     (ctl_wr_i),
    .src_pin_i(ctl_src_pin_i),
    .rise_i   (ctl_rise_i),
    .mask_i   (ctl_mask_i),
    .nm_i     (ctl_nm_i),
    .cfg_o    (cfg)
  );

  toplvl_irq_trigger #(
    .SYNC_STAGES(SYNC_STAGES),
    .PIN_RST_LVL(PIN_RST_LVL)
  ) u_trig (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_i     (pin_i),
    .wdog_eoc_i(wdog_eoc_i),
    .src_pin   (cfg.src_pin),
    .rise      (cfg.rise),
    .pin_edge_o(pin_edge),
    .evt_o     (trig_evt)
  );

  toplvl_irq_state u_state (
    .clk         (clk),
    .rst_n       (rst_n),
    .evt_i       (trig_evt),
    .pend_wr_i   (pend_wr_i),
    .pend_wdata_i(pend_wdata_i),
    .ack_i       (ack_i),
    .ret_i       (ret_i),
    .pend_o      (pend),
    .in_svc_o    (in_svc)
  );

  assign irq_o   = tirq_request(pend, in_svc, cfg.nm_en, cfg.mask_en, gie_i);
  assign pend_o  = pend;
  assign block_o = in_svc;
endmodule

// File: rtl/toplvl_irq_ctrl_chk.sv
module toplvl_irq_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic wdog_eoc_i,
  input logic gie_i,
  input logic pend_wr_i,
  input logic ack_i,
  input logic ret_i,
  input logic irq_o,
  input logic pend_o,
  input logic block_o,
  input logic trig_evt,
  input logic nm_en,
  input logic mask_en,
  input logic src_pin
);
  a_r8_block_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    ack_i |=> block_o);

  a_r8_no_req_in_service: assert property (@(posedge clk) disable iff (!rst_n)
    block_o |-> !irq_o);

  a_r8_ack_clears_pend: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && !pend_wr_i && !trig_evt) |=> !pend_o);

  a_r9_ret_clears_block: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_i && !ack_i) |=> !block_o);

  a_r7_nm_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    nm_en |=> nm_en);

  a_r6_req_qualified: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (pend_o && (nm_en || (mask_en && gie_i))));

  a_r4_wdog_sets_pend: assert property (@(posedge clk) disable iff (!rst_n)
    (!src_pin && wdog_eoc_i) |=> pend_o);

  a_r10_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    trig_evt |=> pend_o);
endmodule

bind toplvl_irq_ctrl toplvl_irq_ctrl_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wdog_eoc_i(wdog_eoc_i),
  .gie_i     (gie_i),
  .pend_wr_i (pend_wr_i),
  .ack_i     (ack_i),
  .ret_i     (ret_i),
  .irq_o     (irq_o),
  .pend_o    (pend_o),
  .block_o   (block_o),
  .trig_evt  (trig_evt),
  .nm_en     (cfg.nm_en),
  .mask_en   (cfg.mask_en),
  .src_pin   (cfg.src_pin)
);

// File: tb/toplvl_irq_ctrl_bench.sv
module toplvl_irq_ctrl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pin_i = 1'b0, wdog_eoc_i = 1'b0, gie_i = 1'b0;
  logic ctl_wr_i = 1'b0, ctl_src_pin_i = 1'b1, ctl_rise_i = 1'b0;
  logic ctl_mask_i = 1'b0, ctl_nm_i = 1'b0;
  logic pend_wr_i = 1'b0, pend_wdata_i = 1'b0, ack_i = 1'b0, ret_i = 1'b0;
  logic irq_o, pend_o, block_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  toplvl_irq_ctrl u_toplvl_irq_ctrl (.*);

  // Row bits: {mask, gie, nm_write, expected request}
  localparam logic [3:0] VEC [0:6] = '{
    4'b0000, 4'b0100, 4'b1000, 4'b1101,
    4'b0011, 4'b1111, 4'b0001
  };

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic ctl_write(input logic src, input logic rise,
                           input logic mask, input logic nm);
    @(negedge clk);
    ctl_wr_i = 1'b1; ctl_src_pin_i = src; ctl_rise_i = rise;
    ctl_mask_i = mask; ctl_nm_i = nm;
    @(negedge clk);
    ctl_wr_i = 1'b0;
  endtask

  task automatic pend_write(input logic v);
    @(negedge clk);
    pend_wr_i = 1'b1; pend_wdata_i = v;
    @(negedge clk);
    pend_wr_i = 1'b0;
  endtask

  task automatic wdog_pulse();
    @(negedge clk);
    wdog_eoc_i = 1'b1;
    @(negedge clk);
    wdog_eoc_i = 1'b0;
  endtask

  task automatic strobe_ack();
    @(negedge clk);
    ack_i = 1'b1;
    @(negedge clk);
    ack_i = 1'b0;
  endtask

  task automatic strobe_ret();
    @(negedge clk);
    ret_i = 1'b1;
    @(negedge clk);
    ret_i = 1'b0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got hung expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 irq", irq_o, 1'b0);
    chk("R1 pend", pend_o, 1'b0);
    chk("R1 block", block_o, 1'b0);
    // R5 / R1: the pin is the source after reset, so a watchdog pulse is ignored
    wdog_pulse();
    repeat (2) @(negedge clk);
    chk("R5 wdog ignored", pend_o, 1'b0);
    // R3 / R1: polarity is falling after reset; a rising change is ignored
    @(negedge clk); pin_i = 1'b1;
    repeat (5) @(negedge clk);
    chk("R3 rise ignored", pend_o, 1'b0);
    pin_i = 1'b0;
    repeat (2) @(negedge clk);
    chk("R3 latency early", pend_o, 1'b0);
    @(negedge clk);
    chk("R3 falling sets", pend_o, 1'b1);
    pend_write(1'b0);
    chk("R10 write clears", pend_o, 1'b0);

    // Mask table (R6 maskable path, R7 set-only path)
    for (int i = 0; i < 7; i++) begin
      ctl_write(1'b1, 1'b0, VEC[i][3], VEC[i][1]);
      gie_i = VEC[i][2];
      pend_write(1'b1);
      chk(VEC[i][1] || i >= 4 ? "R7 table" : "R6 table", irq_o, VEC[i][0]);
      pend_write(1'b0);
    end
    gie_i = 1'b0;

    // R2 rising polarity
    ctl_write(1'b1, 1'b1, 1'b0, 1'b0);
    pin_i = 1'b1;
    repeat (2) @(negedge clk);
    chk("R2 latency early", pend_o, 1'b0);
    @(negedge clk);
    chk("R2 rising sets", pend_o, 1'b1);
    pend_write(1'b0);
    pin_i = 1'b0;
    repeat (5) @(negedge clk);
    chk("R2 fall ignored", pend_o, 1'b0);

    // R4 watchdog source
    ctl_write(1'b0, 1'b1, 1'b0, 1'b0);
    @(negedge clk); wdog_eoc_i = 1'b1;
    @(negedge clk); wdog_eoc_i = 1'b0;
    chk("R4 wdog sets", pend_o, 1'b1);
    pend_write(1'b0);
    pin_i = 1'b1;
    repeat (5) @(negedge clk);
    chk("R4 pin ignored", pend_o, 1'b0);
    pin_i = 1'b0;
    repeat (4) @(negedge clk);

    // R8 / R9 service tracking (set-only enable is set, gie is 0)
    wdog_pulse();
    chk("R7 req with gie 0", irq_o, 1'b1);
    strobe_ack();
    chk("R8 ack clears pend", pend_o, 1'b0);
    chk("R8 block set", block_o, 1'b1);
    wdog_pulse();
    chk("R8 pend in service", pend_o, 1'b1);
    chk("R8 no req in service", irq_o, 1'b0);
    strobe_ret();
    chk("R9 block cleared", block_o, 1'b0);
    chk("R9 waiting req", irq_o, 1'b1);
    @(negedge clk); ack_i = 1'b1; ret_i = 1'b1;
    @(negedge clk); ack_i = 1'b0; ret_i = 1'b0;
    chk("R9 ack wins", block_o, 1'b1);
    strobe_ret();
    chk("R9 ret after", block_o, 1'b0);

    // R10 same-cycle ordering
    pend_write(1'b0);
    @(negedge clk); pend_wr_i = 1'b1; pend_wdata_i = 1'b0; wdog_eoc_i = 1'b1;
    @(negedge clk); pend_wr_i = 1'b0; wdog_eoc_i = 1'b0;
    chk("R10 event beats clear", pend_o, 1'b1);
    @(negedge clk); ack_i = 1'b1; pend_wr_i = 1'b1; pend_wdata_i = 1'b1;
    @(negedge clk); ack_i = 1'b0; pend_wr_i = 1'b0;
    chk("R10 write beats ack", pend_o, 1'b1);
    strobe_ret();

    done = 1'b1;
    finish_run();
  end
endmodule